// File: doc/BRIEF.md
# Buffered Multi-Output PWM Timer

This block is a single motor-control pulse-width channel. A 10-bit up-counter, advanced by a prescaled tick, runs from 0 up to a programmable period limit and then wraps. Eight pulse outputs compare the counter against their own duty values, and each output has its own polarity bit. The host never writes the active duty values directly. It writes a set of staging registers, and the whole set is copied into the active compares on the tick that wraps the counter. A new duty pattern therefore always takes effect at a period boundary and never part-way through a period.

The tick is the system clock divided by 1, 2, 4, 8 or 16. Each wrap sets a sticky period flag. That flag, gated by an enable bit, forms the interrupt request. A module-stop input halts the counter and parks every output at its inactive level. While the module is stopped the host can still program every register. All host access goes through a single-cycle write strobe and a combinational 16-bit read port.

Top module: `pwm_mc_channel`

## Requirements
- R1: After reset, the registers read as follows: control 0, period limit 0x3FF, polarity 0, counter 0, all staging values 0, all active duty values 0. The interrupt output is low.
- R2: While `mstop_i` is high, the counter is held at 0 and every output `k` equals polarity bit `k`. Register writes are still accepted and read back.
- R3: On a tick, if the counter is at or above the period limit it returns to 0. Otherwise it increases by 1. The period is therefore limit+1 ticks.
- R4: With polarity 0, output `k` is high exactly while the counter is below active duty `k`. A duty of 0 gives a constant low output. A duty above the limit gives a constant high output.
- R5: Polarity bit `k` (address 2, bit `k`) inverts output `k` in every state.
- R6: A write to address 8+k sets staging value `k` (11 bits, data[10:0]). The whole staging set is copied into the active duty values (read at 16+k) only on the tick that wraps the counter. A staging write on that same cycle is not copied until the following wrap.
- R7: Control bits [2:0] select the tick: 0 gives every clock, 1 every 2nd, 2 every 4th, 3 every 8th, 4 every 16th clock after the stop is released. Values 5 to 7 behave as 4.
- R8: The period flag (control bit 4) is set on every wrap tick. Writing 1 to it clears it, except on a wrap tick, where the set takes priority.
- R9: `irq_o` is high exactly when the period flag and the enable bit (control bit 3) are both 1.
- R10: The register map is: address 0 control, 1 period limit (data[9:0]), 2 polarity, 3 counter (read-only), 8..15 staging, 16..23 active duty (read-only). Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mstop_i | input | 1 | Module stop: holds the timer halted and outputs inactive |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` (combinational) |
| pwm_o | output | 8 | Pulse outputs |
| irq_o | output | 1 | Period interrupt request |

## Verification
The hardest situations to reach are host writes that land on the exact wrap tick. In one, a flag clear collides with the flag being set. In the other, a staging write collides with the copy into the active duty values. The bench runs a cycle-level arithmetic model of the counter. It waits at a falling edge until that model shows the counter at the limit with an every-clock tick, so the next edge is known to be a wrap, and issues the write there. It then reads the flag and the active duty back. Separately, sweeps over every tick divisor and several short periods drive duties from 0 up past the limit, so the 0% and 100% extremes are exercised in every configuration.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int ADDR_W    = 5;
  localparam int DATA_W    = 16;
  // register map
  localparam logic [ADDR_W-1:0] A_CTRL = 5'd0;
  localparam logic [ADDR_W-1:0] A_LIM  = 5'd1;
  localparam logic [ADDR_W-1:0] A_POL  = 5'd2;
  localparam logic [ADDR_W-1:0] A_CNT  = 5'd3;
  localparam logic [ADDR_W-1:0] A_STG  = 5'd8;
  localparam logic [ADDR_W-1:0] A_ACT  = 5'd16;
  // control field positions
  localparam int C_SEL_W  = 3;
  localparam int C_IE_BIT = 3;
  localparam int C_FL_BIT = 4;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int PRE_W = 4,
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [PRE_W-1:0] mask;

  always_comb begin
    if (int'(sel_i) >= PRE_W) mask = '1;
    else                      mask = PRE_W'((1 << sel_i) - 1);
  end

  always_comb begin
    pre_d = run_i ? pre_q + 1'b1 : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_d;
  end

  assign tick_o = run_i && ((pre_q & mask) == mask);
endmodule

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr #(
  parameter int CW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic [CW-1:0] lim_i,
  output logic [CW-1:0] cnt_o,
  output logic          wrap_o
);
  logic [CW-1:0] cnt_q, cnt_d;

  assign wrap_o = tick_i && (cnt_q >= lim_i);

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i)      cnt_d = '0;
    else if (wrap_o) cnt_d = '0;
    else if (tick_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pwm_out_slice.sv
module pwm_out_slice #(
  parameter int CW = 10,
  localparam int DUW = CW + 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           stg_we_i,
  input  logic [DUW-1:0] stg_wdata_i,
  input  logic           wrap_i,
  input  logic           run_i,
  input  logic [CW-1:0]  cnt_i,
  input  logic           pol_i,
  output logic [DUW-1:0] stg_o,
  output logic [DUW-1:0] act_o,
  output logic           pwm_o
);
  logic [DUW-1:0] stg_q, stg_d, act_q, act_d;

  always_comb begin
    stg_d = stg_we_i ? stg_wdata_i : stg_q;
    act_d = wrap_i ? stg_q : act_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
      act_q <= '0;
    end else begin
      stg_q <= stg_d;
      act_q <= act_d;
    end
  end

  assign stg_o = stg_q;
  assign act_o = act_q;
  assign pwm_o = (run_i && ({1'b0, cnt_i} < act_q)) ^ pol_i;
endmodule

// File: rtl/pwm_mc_channel.sv
module pwm_mc_channel
  import pwm_pkg::*;
#(
  parameter int N_OUT = 8,
  parameter int CW    = 10,
  parameter int PRE_W = 4,
  localparam int DUW  = CW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mstop_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [N_OUT-1:0]  pwm_o,
  output logic              irq_o
);
  // reset: asserted asynchronously, released on the clock
  logic rst_s1_q, rst_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_s1_q <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_q    <= rst_s1_q;
    end
  end

  logic                run;
  logic                tick, wrap_s;
  logic [CW-1:0]       cnt_q;
  logic [CW-1:0]       lim_q, lim_d;
  logic [N_OUT-1:0]    pol_q, pol_d;
  logic [C_SEL_W-1:0]  sel_q, sel_d;
  logic                ie_q, ie_d, flag_q, flag_d;
  logic                we_ctrl, we_lim, we_pol;
  logic [N_OUT-1:0]    we_stg;
  logic [DUW-1:0]      stg_v [N_OUT];
  logic [DUW-1:0]      act_v [N_OUT];
  logic [N_OUT*DUW-1:0] act_flat;
  logic                unused_wdata;

  assign run          = !mstop_i;
  assign unused_wdata = ^wdata_i[DATA_W-1:DUW];

  assign we_ctrl = wr_i && (addr_i == A_CTRL);
  assign we_lim  = wr_i && (addr_i == A_LIM);
  assign we_pol  = wr_i && (addr_i == A_POL);

  pwm_prescaler #(.PRE_W(PRE_W), .SEL_W(C_SEL_W)) u_pre (
    .clk_i (clk_i), .rst_ni(rst_q), .run_i(run), .sel_i(sel_q), .tick_o(tick)
  );

  pwm_period_ctr #(.CW(CW)) u_ctr (
    .clk_i(clk_i), .rst_ni(rst_q), .run_i(run), .tick_i(tick),
    .lim_i(lim_q), .cnt_o(cnt_q), .wrap_o(wrap_s)
  );

  for (genvar k = 0; k < N_OUT; k++) begin : g_slice
    assign we_stg[k] = wr_i && (addr_i == A_STG + ADDR_W'(k));
    assign act_flat[k*DUW +: DUW] = act_v[k];
    pwm_out_slice #(.CW(CW)) u_slice (
      .clk_i      (clk_i),
      .rst_ni     (rst_q),
      .stg_we_i   (we_stg[k]),
      .stg_wdata_i(wdata_i[DUW-1:0]),
      .wrap_i     (wrap_s),
      .run_i      (run),
      .cnt_i      (cnt_q),
      .pol_i      (pol_q[k]),
      .stg_o      (stg_v[k]),
      .act_o      (act_v[k]),
      .pwm_o      (pwm_o[k])
    );
  end

  // control and configuration: next state
  always_comb begin
    sel_d  = we_ctrl ? wdata_i[C_SEL_W-1:0] : sel_q;
    ie_d   = we_ctrl ? wdata_i[C_IE_BIT]    : ie_q;
    lim_d  = we_lim  ? wdata_i[CW-1:0]      : lim_q;
    pol_d  = we_pol  ? wdata_i[N_OUT-1:0]   : pol_q;
    flag_d = flag_q;
    if (wrap_s)                             flag_d = 1'b1;
    else if (we_ctrl && wdata_i[C_FL_BIT])  flag_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_q) begin
    if (!rst_q) begin
      sel_q  <= '0;
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
      lim_q  <= '1;
      pol_q  <= '0;
    end else begin
      sel_q  <= sel_d;
      ie_q   <= ie_d;
      flag_q <= flag_d;
      lim_q  <= lim_d;
      pol_q  <= pol_d;
    end
  end

  assign irq_o = flag_q && ie_q;

  // read mux
  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL: rdata_o = DATA_W'({flag_q, ie_q, sel_q});
      A_LIM:  rdata_o = DATA_W'(lim_q);
      A_POL:  rdata_o = DATA_W'(pol_q);
      A_CNT:  rdata_o = DATA_W'(cnt_q);
      default: begin
        for (int k = 0; k < N_OUT; k++) begin
          if (addr_i == A_STG + ADDR_W'(k)) rdata_o = DATA_W'(stg_v[k]);
          if (addr_i == A_ACT + ADDR_W'(k)) rdata_o = DATA_W'(act_v[k]);
        end
      end
    endcase
  end
endmodule

// File: rtl/pwm_mc_channel_chk.sv
module pwm_mc_channel_chk #(
  parameter int N_OUT = 8,
  parameter int CW    = 10,
  parameter int SEL_W = 3,
  localparam int DUW  = CW + 1
) (
  input logic                 clk_i,
  input logic                 rst_n,
  input logic                 mstop_i,
  input logic                 tick,
  input logic                 wrap_s,
  input logic [CW-1:0]        cnt_q,
  input logic [SEL_W-1:0]     sel_q,
  input logic                 ie_q,
  input logic                 flag_q,
  input logic                 irq_o,
  input logic [N_OUT-1:0]     pol_q,
  input logic [N_OUT*DUW-1:0] act_flat,
  input logic [N_OUT-1:0]     pwm_o
);
  a_r2_stop_clears_cnt: assert property (@(posedge clk_i) disable iff (!rst_n)
    mstop_i |=> (cnt_q == '0));

  a_r2_stop_idle: assert property (@(posedge clk_i) disable iff (!rst_n)
    mstop_i |-> (pwm_o == pol_q));

  a_r3_wrap_to_zero: assert property (@(posedge clk_i) disable iff (!rst_n)
    wrap_s |=> (cnt_q == '0));

  a_r3_step: assert property (@(posedge clk_i) disable iff (!rst_n)
    (tick && !wrap_s && !mstop_i) |=> (cnt_q == CW'($past(cnt_q) + 1'b1)));

  a_r6_act_hold: assert property (@(posedge clk_i) disable iff (!rst_n)
    !wrap_s |=> $stable(act_flat));

  a_r7_div16_gap: assert property (@(posedge clk_i) disable iff (!rst_n)
    (tick && sel_q >= 3'd4) |=> (!tick || sel_q < 3'd4));

  a_r8_flag_sets: assert property (@(posedge clk_i) disable iff (!rst_n)
    wrap_s |=> flag_q);

  a_r9_irq_masked: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(ie_q && flag_q) |-> !irq_o);

  for (genvar k = 0; k < N_OUT; k++) begin : g_zero
    a_r4_zero_duty: assert property (@(posedge clk_i) disable iff (!rst_n)
      (act_flat[k*DUW +: DUW] == '0) |-> (pwm_o[k] == pol_q[k]));
  end
endmodule

bind pwm_mc_channel pwm_mc_channel_chk #(.N_OUT(N_OUT), .CW(CW), .SEL_W(3)) chk_i (
  .clk_i   (clk_i),
  .rst_n   (rst_q),
  .mstop_i (mstop_i),
  .tick    (tick),
  .wrap_s  (wrap_s),
  .cnt_q   (cnt_q),
  .sel_q   (sel_q),
  .ie_q    (ie_q),
  .flag_q  (flag_q),
  .irq_o   (irq_o),
  .pol_q   (pol_q),
  .act_flat(act_flat),
  .pwm_o   (pwm_o)
);

// File: tb/pwm_mc_channel_tb_top.sv
module pwm_mc_channel_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mstop = 1'b1;
  logic        wr = 1'b0;
  logic [4:0]  addr = 5'd3;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [7:0]  pwm;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit chk_on = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pwm_mc_channel dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mstop_i(mstop), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm), .irq_o(irq)
  );

  // arithmetic model of the requirements
  int m_cnt, m_lim, m_pol, m_sel, m_ie, m_flag, m_div;
  int m_stg [8];
  int m_act [8];

  always @(posedge clk) begin
    int n;
    bit run, tk, wp;
    if (!rst_n) begin
      m_cnt = 0; m_lim = 1023; m_pol = 0; m_sel = 0; m_ie = 0; m_flag = 0; m_div = 0;
      for (int k = 0; k < 8; k++) begin m_stg[k] = 0; m_act[k] = 0; end
    end else begin
      run = !mstop;
      n   = 1 << ((m_sel > 4) ? 4 : m_sel);
      tk  = run && ((m_div % n) == n - 1);
      wp  = tk && (m_cnt >= m_lim);
      if (wp) for (int k = 0; k < 8; k++) m_act[k] = m_stg[k];
      if (!run || wp) m_cnt = 0;
      else if (tk)    m_cnt = m_cnt + 1;
      m_div = run ? m_div + 1 : 0;
      if (wp) m_flag = 1;
      else if (wr && addr == 5'd0 && wdata[4]) m_flag = 0;
      if (wr) begin
        if (addr == 5'd0) begin m_sel = int'(wdata[2:0]); m_ie = int'(wdata[3]); end
        if (addr == 5'd1) m_lim = int'(wdata[9:0]);
        if (addr == 5'd2) m_pol = int'(wdata[7:0]);
        if (addr >= 5'd8 && addr < 5'd16) m_stg[addr - 8] = int'(wdata[10:0]);
      end
    end
  end

  function automatic int exp_read(input logic [4:0] a);
    if (a == 5'd0) return m_flag * 16 + m_ie * 8 + m_sel;
    if (a == 5'd1) return m_lim;
    if (a == 5'd2) return m_pol;
    if (a == 5'd3) return m_cnt;
    if (a >= 5'd8 && a < 5'd16) return m_stg[a - 8];
    if (a >= 5'd16 && a < 5'd24) return m_act[a - 16];
    return 0;
  endfunction

  function automatic logic [7:0] exp_pwm();
    logic [7:0] r;
    for (int k = 0; k < 8; k++)
      r[k] = ((!mstop) && (m_cnt < m_act[k])) ^ m_pol[k];
    return r;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    #1;
    if (chk_on && !done) begin
      check("R4 R5 R2 outputs", int'(pwm), int'(exp_pwm()));
      check("R9 irq", int'(irq), m_ie & m_flag);
      check("R3 R7 R10 read port", int'(rdata), exp_read(addr));
    end
  end

  task automatic wreg(input logic [4:0] a, input logic [15:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; addr = 5'd3;
  endtask

  task automatic rchk(input logic [4:0] a, input string tag);
    addr = a;
    #2;
    check(tag, int'(rdata), exp_read(a));
  endtask

  task automatic wait_cnt(input int v);
    while (m_cnt != v) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset values
    check("R1 pwm", int'(pwm), 0);
    check("R1 irq", int'(irq), 0);
    rchk(5'd0, "R1 ctrl");  check("R1 ctrl literal", int'(rdata), 0);
    rchk(5'd1, "R1 limit"); check("R1 limit literal", int'(rdata), 16'h3FF);
    for (int a = 2; a < 24; a++) rchk(5'(a), "R1 reset read");
    @(negedge clk);
    chk_on = 1;

    // R2: stopped, writes accepted, outputs at polarity
    wreg(5'd2, 16'h00A5);
    wreg(5'd1, 16'd5);
    for (int k = 0; k < 8; k++) wreg(5'(8 + k), 16'(k));
    repeat (5) @(negedge clk);
    check("R2 stopped outputs", int'(pwm), 8'hA5);
    rchk(5'd3, "R2 counter held");
    rchk(5'd9, "R2 staging written");
    rchk(5'd17, "R6 active unchanged while stopped");
    @(negedge clk);

    // R3 R4 R5 R7: sweep divisors, limits, duties and polarities
    mstop = 1'b0;
    for (int si = 0; si < 6; si++) begin
      for (int li = 0; li < 3; li++) begin
        int sel, lim, n;
        sel = (si == 5) ? 6 : si;
        lim = (li == 0) ? 0 : (li == 1) ? 3 : 6;
        n   = 1 << ((sel > 4) ? 4 : sel);
        wreg(5'd0, 16'(sel));
        wreg(5'd1, 16'(lim));
        wreg(5'd2, 16'((si * 3 + li) * 37));
        for (int k = 0; k < 8; k++) wreg(5'(8 + k), 16'((k + si + li) % (lim + 3)));
        repeat ((lim + 1) * n * 3 + 10) @(negedge clk);
        rchk(5'(16 + (si + li) % 8), "R6 active after wraps");
      end
    end
    for (int a = 0; a < 32; a++) rchk(5'(a), "R10 map sweep");
    @(negedge clk);

    // R8 R9: flag and interrupt
    wreg(5'd2, 16'h0000);
    wreg(5'd1, 16'd3);
    wreg(5'd0, 16'h0000);
    repeat (10) @(negedge clk);
    rchk(5'd0, "R8 flag set after wrap");
    check("R9 irq masked", int'(irq), 0);
    wreg(5'd0, 16'h0008);
    check("R9 irq enabled", int'(irq), 1);
    wait_cnt(1);
    wreg(5'd0, 16'h0018);
    rchk(5'd0, "R8 flag cleared off wrap");
    check("R9 irq after clear", int'(irq), 0);
    @(negedge clk);

    // collision: clear at the wrap tick, set wins
    wait_cnt(3);
    wreg(5'd0, 16'h0018);
    rchk(5'd0, "R8 set beats clear");
    check("R8 flag literal", int'(rdata[4]), 1);
    @(negedge clk);

    // collision: staging write at the wrap tick
    wreg(5'd8, 16'd1);
    wait_cnt(3);
    wreg(5'd8, 16'd4);
    rchk(5'd16, "R6 copy took old staging");
    check("R6 old staging literal", int'(rdata), 1);
    @(negedge clk);
    wait_cnt(3);
    @(negedge clk);
    rchk(5'd16, "R6 copy on next wrap");
    check("R6 new staging literal", int'(rdata), 4);
    check("R4 full duty", int'(pwm[0]), 1);
    @(negedge clk);

    // R2: stop again mid-run
    mstop = 1'b1;
    wreg(5'd2, 16'h003C);
    @(negedge clk);
    check("R2 outputs park", int'(pwm), 8'h3C);
    rchk(5'd3, "R2 counter cleared");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule